// File: doc/BRIEF.md
# Clock Generator Mode and Configuration Selector

This block is the digital control core of a clock generator with three PLLs. It works out the operating mode from a manual-control register bit and the state of a three-level programming-select pin. It then gives the six general-purpose input pins and the two general-purpose output pins the function that mode calls for. For each PLL it picks the active configuration word from a register bank. A configuration word carries the divider and loop-filter settings. The block also picks the output-bank post-divider that the chosen word requests.

The programming-select pin is a level input of two bits: `00` means driven low, `01` means driven high, and `1x` means left floating. There are four modes. In the single-PLL manual mode, three pins index eight configurations of PLL0. Four of these eight are borrowed from the upper register sets of PLL1 and PLL2, so those two PLLs run on their first set. In the all-PLL manual mode, each PLL is indexed by its own pair of pins. In the two programming modes, the pins carry the serial bus or test-port signals straight through.

Index pins are resynchronised and must hold still before they take effect. This keeps the PLL controls from seeing a partial or glitched index.

Top module: `pll_cfg_selector`

## Requirements
- R1: `mode` decodes as follows. Code 0 (PLL0-only manual) when `mfc`=1 and `prog_sel` is floating. Code 1 (all-PLL manual) when `mfc`=1 and `prog_sel` is driven. Code 2 (I2C programming) when `mfc`=0 and `prog_sel` is high or floating. Code 3 (JTAG programming) when `mfc`=0 and `prog_sel` is low.
- R2: A change on `gin` reaches the configuration outputs no earlier than the third rising clock edge after it is sampled, and by the fourth. A `gin` value that lasts a single clock never reaches the configuration outputs.
- R3: In mode 0, the index {gin[2],gin[1],gin[0]} (gin[2] most significant) with values 0 to 3 selects PLL0's own set of the same number. Set s of PLL p is the word at `bank_words[(p*4+s)*CFG_W +: CFG_W]`.
- R4: In mode 0, index 4 selects PLL1 set 2, index 5 selects PLL1 set 3, index 6 selects PLL2 set 2, and index 7 selects PLL2 set 3.
- R5: In mode 0, PLL1 and PLL2 output set 0 whatever the index.
- R6: In mode 0, `suspend` follows gin[3] and `ref_sel` follows gin[5], and gin[4] has no effect on any output. In every other mode, `suspend` and `ref_sel` are 0.
- R7: In modes 0 and 1, gout[0] shows `lock_lost` and gout[1] shows `clkin_lost`.
- R8: For each PLL, bit 0 of its selected word picks the post-divider. A 0 selects that PLL's slice of `pdiv_a` and a 1 selects its slice of `pdiv_b`.
- R9: In mode 1, with the default parameters, PLL0 takes set gin[1:0], PLL1 takes set gin[3:2] and PLL2 takes set gin[5:4].
- R10: Serial routing without delay: `ser_data`=gin[0] and `ser_clk`=gin[1] in modes 2 and 3. In mode 3 only, `jtag_tms`=gin[2], `jtag_trst_n`=gin[4] and gout[0]=`tdo`; outside mode 3, `jtag_tms` and `jtag_trst_n` are 0. In mode 2, gout is 0.
- R11: In modes 2 and 3, every PLL outputs its set 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mfc | input | 1 | Manual-frequency-control register bit |
| prog_sel | input | 2 | Programming-select pin level: 00 low, 01 high, 1x floating |
| gin | input | 6 | General-purpose input pins |
| lock_lost | input | 1 | PLL loss-of-lock status |
| clkin_lost | input | 1 | Primary input clock missing status |
| tdo | input | 1 | Test-port serial data out from the JTAG engine |
| bank_words | input | 12*CFG_W | Configuration register sets, four per PLL |
| pdiv_a | input | 3*P_W | First post-divider setting per output bank |
| pdiv_b | input | 3*P_W | Second post-divider setting per output bank |
| mode | output | 2 | Decoded operating mode |
| cfg_sel | output | 3*CFG_W | Active configuration word per PLL |
| pdiv_sel | output | 3*P_W | Active post-divider per output bank |
| suspend | output | 1 | Suspend all PLL outputs |
| ref_sel | output | 1 | Reference clock select |
| ser_data | output | 1 | Serial data to the programming engine |
| ser_clk | output | 1 | Serial clock to the programming engine |
| jtag_tms | output | 1 | Test-port mode select |
| jtag_trst_n | output | 1 | Test-port reset, active low |
| gout | output | 2 | General-purpose output pins |

## Verification
The bench walks all eight PLL0 indices. A wrong borrow table would show up as PLL0 holding the wrong PLL's word at indices 4 to 7, or as PLL1 and PLL2 drifting off set 0. It sends a one-clock pulse on the index pins, which a design without the stability check would pass to the PLLs as a glitch. It also counts the edges to the new selection, which catches a filter that is too short or too long. It toggles gin[4] in the PLL0-only mode and checks that no output moves. It also checks that the serial clock and data pass through the programming modes without delay, because a design that filtered them would eat the serial clock.

// File: rtl/pll_cfg_selector.sv
module pll_cfg_selector #(
  parameter int CFG_W    = 16,
  parameter int P_W      = 8,
  parameter int IDX0_LSB = 0,
  parameter int IDX1_LSB = 2,
  parameter int IDX2_LSB = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mfc,
  input  logic [1:0]            prog_sel,
  input  logic [5:0]            gin,
  input  logic                  lock_lost,
  input  logic                  clkin_lost,
  input  logic                  tdo,
  input  logic [12*CFG_W-1:0]   bank_words,
  input  logic [3*P_W-1:0]      pdiv_a,
  input  logic [3*P_W-1:0]      pdiv_b,
  output logic [1:0]            mode,
  output logic [3*CFG_W-1:0]    cfg_sel,
  output logic [3*P_W-1:0]      pdiv_sel,
  output logic                  suspend,
  output logic                  ref_sel,
  output logic                  ser_data,
  output logic                  ser_clk,
  output logic                  jtag_tms,
  output logic                  jtag_trst_n,
  output logic [1:0]            gout
);
  localparam int NPLL = 3;
  localparam int NSET = 4;
  localparam logic [1:0] M_ONE = 2'd0, M_ALL = 2'd1, M_I2C = 2'd2, M_JTAG = 2'd3;
  localparam int LSB [NPLL] = '{IDX0_LSB, IDX1_LSB, IDX2_LSB};

  logic floating, driven_low;
  assign floating   = prog_sel[1];
  assign driven_low = (prog_sel == 2'b00);
  assign mode = mfc ? (floating ? M_ONE : M_ALL) : (driven_low ? M_JTAG : M_I2C);

  logic manual, jtag;
  assign manual = (mode == M_ONE) || (mode == M_ALL);
  assign jtag   = (mode == M_JTAG);

  logic [5:0] s1, s2, s3, gq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; gq <= '0;
    end else begin
      s1 <= gin;
      s2 <= s1;
      s3 <= s2;
      if (s2 == s3) gq <= s2;
    end
  end

  logic [1:0] src_pll [NPLL];
  logic [1:0] src_set [NPLL];

  always_comb begin
    for (int k = 0; k < NPLL; k++) begin
      src_pll[k] = 2'(k);
      src_set[k] = 2'd0;
    end
    case (mode)
      M_ONE: begin
        if (gq[2]) begin
          src_pll[0] = gq[1] ? 2'd2 : 2'd1;
          src_set[0] = {1'b1, gq[0]};
        end else begin
          src_set[0] = gq[1:0];
        end
      end
      M_ALL: begin
        for (int k = 0; k < NPLL; k++) src_set[k] = gq[LSB[k] +: 2];
      end
      default: ;
    endcase
  end

  for (genvar k = 0; k < NPLL; k++) begin : g_pll
    logic [3:0]       fi;
    logic [CFG_W-1:0] w;
    assign fi = {src_pll[k], 2'b00} + {2'b00, src_set[k]};
    assign w  = bank_words[fi*CFG_W +: CFG_W];
    assign cfg_sel[k*CFG_W +: CFG_W] = w;
    assign pdiv_sel[k*P_W +: P_W] = w[0] ? pdiv_b[k*P_W +: P_W] : pdiv_a[k*P_W +: P_W];

    p_post_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pdiv_sel[k*P_W +: P_W] == (cfg_sel[k*CFG_W] ? pdiv_b[k*P_W +: P_W] : pdiv_a[k*P_W +: P_W]));
  end

  assign suspend     = (mode == M_ONE) & gq[3];
  assign ref_sel     = (mode == M_ONE) & gq[5];
  assign ser_data    = !manual & gin[0];
  assign ser_clk     = !manual & gin[1];
  assign jtag_tms    = jtag & gin[2];
  assign jtag_trst_n = jtag & gin[4];
  assign gout = manual ? {clkin_lost, lock_lost} : {1'b0, jtag & tdo};

  p_sel_after_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gq) |-> $past(s2 == s3));

  p_pinned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ONE) |-> (cfg_sel[CFG_W +: CFG_W] == bank_words[4*CFG_W +: CFG_W]
                      && cfg_sel[2*CFG_W +: CFG_W] == bank_words[8*CFG_W +: CFG_W]));

  p_status_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    manual |-> (gout == {clkin_lost, lock_lost}));

  p_trst_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !jtag |-> (!jtag_trst_n && !jtag_tms));

  p_prog_set0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !manual |-> (cfg_sel[CFG_W-1:0] == bank_words[CFG_W-1:0] && !suspend && !ref_sel));
endmodule

// File: tb/tb_pll_cfg_selector.sv
module tb_pll_cfg_selector;
  localparam int CLK_P = 10;
  localparam int CW = 16;
  localparam int PW = 8;

  logic clk = 0, rst_n = 0, mfc = 0, lock_lost = 0, clkin_lost = 0, tdo = 0;
  logic [1:0] prog_sel = 2'b10;
  logic [5:0] gin = 0;
  logic [12*CW-1:0] bank_words;
  logic [3*PW-1:0] pdiv_a, pdiv_b;
  logic [1:0] mode, gout;
  logic [3*CW-1:0] cfg_sel;
  logic [3*PW-1:0] pdiv_sel;
  logic suspend, ref_sel, ser_data, ser_clk, jtag_tms, jtag_trst_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pll_cfg_selector dut (.clk, .rst_n, .mfc, .prog_sel, .gin, .lock_lost, .clkin_lost, .tdo,
    .bank_words, .pdiv_a, .pdiv_b, .mode, .cfg_sel, .pdiv_sel, .suspend, .ref_sel,
    .ser_data, .ser_clk, .jtag_tms, .jtag_trst_n, .gout);

  function automatic logic [CW-1:0] ew(int p, int s);
    return {4'h5, 2'b00, 2'(p), 2'b00, 2'(s), 3'b000, 1'((p + s) % 2)};
  endfunction

  function automatic logic [PW-1:0] ep(int p, logic [CW-1:0] w);
    return w[0] ? 8'(8'h20 + p) : 8'(8'h10 + p);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R3 reset cfg0", 64'(cfg_sel[CW-1:0]), 64'(ew(0, 0)));
    chk("R1 reset mode", 64'(mode), 64'd0);
  endtask

  task automatic t_one_all_idx();
    mfc = 1; prog_sel = 2'b10;
    for (int i = 0; i < 8; i++) begin
      int p, s;
      gin = 6'(i);
      settle();
      p = (i < 4) ? 0 : ((i < 6) ? 1 : 2);
      s = (i < 4) ? i : 2 + (i % 2);
      chk(i < 4 ? "R3 own set" : "R4 borrowed set", 64'(cfg_sel[CW-1:0]), 64'(ew(p, s)));
      chk("R5 pll1 pinned", 64'(cfg_sel[CW +: CW]), 64'(ew(1, 0)));
      chk("R5 pll2 pinned", 64'(cfg_sel[2*CW +: CW]), 64'(ew(2, 0)));
      chk("R8 pdiv0", 64'(pdiv_sel[PW-1:0]), 64'(ep(0, ew(p, s))));
    end
    chk("R1 mode one", 64'(mode), 64'd0);
  endtask

  task automatic t_one_pins();
    logic [63:0] snap;
    mfc = 1; prog_sel = 2'b11;
    gin = 6'b101_010; lock_lost = 1; clkin_lost = 0;
    settle();
    chk("R6 suspend", 64'(suspend), 64'd1);
    chk("R6 ref_sel", 64'(ref_sel), 64'd1);
    chk("R7 gout", 64'(gout), 64'b01);
    lock_lost = 0; clkin_lost = 1; #1;
    chk("R7 gout clkin", 64'(gout), 64'b10);
    snap = {cfg_sel, suspend, ref_sel, pdiv_sel[7:0]};
    gin[4] = 1;
    settle();
    chk("R6 gin4 ignored", {cfg_sel, suspend, ref_sel, pdiv_sel[7:0]}, snap);
    chk("R10 no trst outside jtag", 64'(jtag_trst_n), 64'd0);
    gin = 6'b000_011;
    settle();
    chk("R6 suspend low", 64'(suspend), 64'd0);
  endtask

  task automatic t_glitch_latency();
    mfc = 1; prog_sel = 2'b10;
    gin = 6'd3; settle();
    gin = 6'd5; @(negedge clk); gin = 6'd3;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk("R2 glitch filtered", 64'(cfg_sel[CW-1:0]), 64'(ew(0, 3)));
    end
    gin = 6'd5;
    repeat (3) @(negedge clk);
    chk("R2 not early", 64'(cfg_sel[CW-1:0]), 64'(ew(0, 3)));
    @(negedge clk);
    chk("R2 by fourth edge", 64'(cfg_sel[CW-1:0]), 64'(ew(1, 3)));
  endtask

  task automatic t_all_mode();
    mfc = 1; prog_sel = 2'b00;
    foreach (gin[b]) ;
    for (int v = 0; v < 3; v++) begin
      logic [5:0] g;
      g = (v == 0) ? 6'b10_01_11 : (v == 1) ? 6'b00_11_10 : 6'b11_10_01;
      gin = g; settle();
      chk("R1 mode all", 64'(mode), 64'd1);
      for (int k = 0; k < 3; k++) begin
        chk("R9 all pll map", 64'(cfg_sel[k*CW +: CW]), 64'(ew(k, int'(g[2*k +: 2]))));
        chk("R8 pdiv all", 64'(pdiv_sel[k*PW +: PW]), 64'(ep(k, ew(k, int'(g[2*k +: 2])))));
      end
      chk("R6 no suspend in all", 64'({suspend, ref_sel}), 64'd0);
      lock_lost = 1; clkin_lost = 1; #1;
      chk("R7 gout all", 64'(gout), 64'b11);
      lock_lost = 0; clkin_lost = 0;
    end
  endtask

  task automatic t_prog();
    mfc = 0; prog_sel = 2'b01; gin = 6'b111_111; settle();
    chk("R1 mode i2c", 64'(mode), 64'd2);
    chk("R11 set0 i2c", 64'(cfg_sel), 64'({ew(2, 0), ew(1, 0), ew(0, 0)}));
    chk("R10 i2c tms/trst", 64'({jtag_tms, jtag_trst_n}), 64'd0);
    tdo = 1; #1;
    chk("R10 i2c gout", 64'(gout), 64'd0);
    gin = 6'b000_010; #1;
    chk("R10 i2c serial", 64'({ser_clk, ser_data}), 64'b10);
    prog_sel = 2'b10; #1;
    chk("R1 mode float i2c", 64'(mode), 64'd2);
    prog_sel = 2'b00; gin = 6'b010_101; #1;
    chk("R1 mode jtag", 64'(mode), 64'd3);
    chk("R10 jtag pins", 64'({jtag_trst_n, jtag_tms, ser_clk, ser_data}), 64'b1101);
    chk("R10 jtag tdo", 64'(gout), 64'b01);
    tdo = 0; #1;
    chk("R10 jtag tdo low", 64'(gout), 64'b00);
    settle();
    chk("R11 set0 jtag", 64'(cfg_sel), 64'({ew(2, 0), ew(1, 0), ew(0, 0)}));
    chk("R6 jtag suspend", 64'({suspend, ref_sel}), 64'd0);
  endtask

  initial begin
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 4; s++) bank_words[(p*4+s)*CW +: CW] = ew(p, s);
      pdiv_a[p*PW +: PW] = 8'(8'h10 + p);
      pdiv_b[p*PW +: PW] = 8'(8'h20 + p);
    end
    mfc = 1; prog_sel = 2'b10;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_one_all_idx();
    t_one_pins();
    t_glitch_latency();
    t_all_mode();
    t_prog();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule